// File: doc/BRIEF.md
# ADC conversion trigger controller

This block decides when an analog-to-digital conversion begins. One of three trigger sources can be selected: a software write strobe arriving on the bus clock, a single-cycle pulse from a PWM generator that runs on the converter's operation clock, or an external input pin. A selected bus-side source passes through two bus-clock register stages and then a two-stage synchroniser into the operation clock domain. The PWM pulse runs through a three-stage operation-clock pipeline. The block acts only on a rising edge of the selected source.

Once an edge is accepted, a down-counter loaded from the delay input runs for the programmed number of operation-clock cycles. The block then raises a single-cycle start-of-sampling pulse. A busy flag covers the counting window. Rising edges that arrive while the block is busy are dropped. A change of the source selection reaches the operation clock domain only while the block is idle.

Top module: `adc_trig_ctrl`

## Requirements
- R1: While rst_ni is low, and on the first cycles after it is released, start_o and busy_o are both low. Asserting rst_ni in the middle of a delay window clears busy_o and cancels the pending start.
- R2: Mode 2'b00 selects the software trigger. A high sw_wr_i seen at one bus-clock edge sets a trigger bit, and that bit clears itself at the next bus-clock edge. The bit passes two bus-clock stages and then two operation-clock stages. With a delay of 0, start_o is high in the operation cycle that follows the second operation stage turning high.
- R3: Mode 2'b10 selects ext_i. The pin is registered at a bus-clock edge, and must be high for at least one full bus-clock cycle so that an edge captures it. From that register onward it follows the same path and latency as the software bit in R2.
- R4: Mode 2'b01 selects pwm_i. A pulse seen at operation-clock edge k gives start_o high in the cycle after edge k+2 when the delay is 0, which is three operation cycles.
- R5: A delay_i value N, captured when the edge is accepted, moves start_o exactly N operation-clock cycles later than the zero-delay timing.
- R6: Each accepted trigger gives exactly one start_o pulse, one operation cycle wide.
- R7: For N > 0, busy_o rises at the operation edge after acceptance. It stays high through the cycle in which start_o is high and falls at the next edge. For N = 0, busy_o stays low.
- R8: A rising edge that arrives while busy_o is high is ignored. It gives no extra start and does not shift the pending one.
- R9: A source held high gives one start only. A new start needs the source to go low and then high again.
- R10: Only the source chosen by mode_i can trigger. Mode 2'b11 disables all three sources.
- R11: A new mode_i value is taken into the operation clock domain only while busy_o is low. A mode change during a delay window does not disturb the pending start, and it governs the triggers that come after that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus_i | input | 1 | Bus clock |
| clk_op_i | input | 1 | Converter operation clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| mode_i | input | 2 | Source select: 00 software, 01 PWM, 10 external, 11 off |
| sw_wr_i | input | 1 | Software trigger write strobe, bus clock domain |
| pwm_i | input | 1 | Single-cycle PWM trigger pulse, operation clock domain |
| ext_i | input | 1 | External trigger pin, asynchronous |
| delay_i | input | DLY_W | Start delay in operation-clock cycles |
| start_o | output | 1 | Start-of-sampling pulse, operation clock domain |
| busy_o | output | 1 | High while a delay window is running |

## Verification
The assertions assume the following about the inputs:
- sw_wr_i is a one-cycle write strobe.
- pwm_i is one operation cycle wide.
- mode_i and delay_i do not move while a source edge is travelling through the synchronisers.

The bench respects these limits. It applies a new mode and delay, then waits several idle operation cycles before it drives any source. It drives every input one nanosecond after an operation-clock edge. Both clocks run at the same rate with a fixed phase offset, so the number of synchroniser edges, and therefore each expected start cycle, is deterministic.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  typedef enum logic [1:0] {
    MODE_SW  = 2'd0,
    MODE_PWM = 2'd1,
    MODE_EXT = 2'd2,
    MODE_OFF = 2'd3
  } trig_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } dly_state_e;
endpackage

// File: rtl/trig_shreg.sv
module trig_shreg #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] r_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= {r_q[DEPTH-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = r_q[DEPTH-1];
endmodule

// File: rtl/trig_bus_side.sv
module trig_bus_side
  import adc_trig_pkg::*;
#(
  parameter int BUS_STAGES = 2
) (
  input  logic       clk_bus_i,
  input  logic       rst_ni,
  input  trig_mode_e mode_i,
  input  logic       sw_wr_i,
  input  logic       ext_i,
  output logic       lvl_o
);
  logic sw_bit_q;
  logic ext_q;
  logic src;

  // trigger bit self-clears one bus cycle after the write
  always_ff @(posedge clk_bus_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_bit_q <= 1'b0;
      ext_q    <= 1'b0;
    end else begin
      sw_bit_q <= sw_wr_i;
      ext_q    <= ext_i;
    end
  end

  always_comb begin
    unique case (mode_i)
      MODE_SW:  src = sw_bit_q;
      MODE_EXT: src = ext_q;
      default:  src = 1'b0;
    endcase
  end

  trig_shreg #(.DEPTH(BUS_STAGES)) u_bus_pipe (
    .clk_i (clk_bus_i),
    .rst_ni(rst_ni),
    .d_i   (src),
    .q_o   (lvl_o)
  );

  AST_SW_SELF_CLEAR: assert property (@(posedge clk_bus_i) disable iff (!rst_ni)
    (sw_bit_q && !sw_wr_i) |=> !sw_bit_q); // R2
endmodule

// File: rtl/trig_op_sync.sv
module trig_op_sync
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PWM_STAGES  = 3
) (
  input  logic       clk_op_i,
  input  logic       rst_ni,
  input  logic       bus_lvl_i,
  input  logic       pwm_i,
  input  trig_mode_e mode_q_i,
  input  logic       mode_stable_i,
  output logic       rise_o
);
  logic bus_sync;
  logic pwm_dly;
  logic sel;
  logic sel_q;

  trig_shreg #(.DEPTH(SYNC_STAGES)) u_sync (
    .clk_i (clk_op_i),
    .rst_ni(rst_ni),
    .d_i   (bus_lvl_i),
    .q_o   (bus_sync)
  );

  trig_shreg #(.DEPTH(PWM_STAGES)) u_pwm_pipe (
    .clk_i (clk_op_i),
    .rst_ni(rst_ni),
    .d_i   (pwm_i),
    .q_o   (pwm_dly)
  );

  always_comb begin
    unique case (mode_q_i)
      MODE_PWM:          sel = pwm_dly;
      MODE_SW, MODE_EXT: sel = bus_sync;
      default:           sel = 1'b0;
    endcase
  end

  always_ff @(posedge clk_op_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel;
  end

  // no edge in the cycle after a mode switch
  assign rise_o = sel && !sel_q && mode_stable_i;

  AST_RISE_SINGLE: assert property (@(posedge clk_op_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R9
  AST_OFF_QUIET: assert property (@(posedge clk_op_i) disable iff (!rst_ni)
    (mode_q_i == MODE_OFF) |-> !rise_o); // R10
endmodule

// File: rtl/trig_delay_ctrl.sv
module trig_delay_ctrl
  import adc_trig_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk_op_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             start_o,
  output logic             busy_o
);
  localparam logic [DLY_W-1:0] CNT_ONE = DLY_W'(1);

  dly_state_e       state_q;
  logic [DLY_W-1:0] cnt_q;
  logic             accept;

  assign accept = rise_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_op_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept && delay_i != '0) begin
          state_q <= ST_WAIT;
          cnt_q   <= delay_i;
        end
        ST_WAIT: if (cnt_q == CNT_ONE) begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q - CNT_ONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign start_o = (accept && delay_i == '0) || (state_q == ST_WAIT && cnt_q == CNT_ONE);
  assign busy_o  = (state_q == ST_WAIT);

  AST_BUSY_HOLD: assert property (@(posedge clk_op_i) disable iff (!rst_ni)
    (busy_o && !start_o) |=> busy_o); // R7
  AST_BUSY_DROP: assert property (@(posedge clk_op_i) disable iff (!rst_ni)
    (busy_o && start_o) |=> !busy_o); // R7
  AST_CNT_STEP: assert property (@(posedge clk_op_i) disable iff (!rst_ni)
    (busy_o && !start_o) |=> (cnt_q == $past(cnt_q) - CNT_ONE)); // R8
  AST_CNT_LIVE: assert property (@(posedge clk_op_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q != '0)); // R5
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int DLY_W       = 8,
  parameter int BUS_STAGES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_bus_i,
  input  logic             clk_op_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             sw_wr_i,
  input  logic             pwm_i,
  input  logic             ext_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             start_o,
  output logic             busy_o
);
  localparam int PWM_STAGES = SYNC_STAGES + 1;

  trig_mode_e mode_q;
  trig_mode_e mode_d;
  logic       bus_lvl;
  logic       rise;

  // op-domain copy of the mode, refreshed only while idle
  always_ff @(posedge clk_op_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      mode_d <= MODE_OFF;
    end else begin
      if (!busy_o) mode_q <= trig_mode_e'(mode_i);
      mode_d <= mode_q;
    end
  end

  trig_bus_side #(.BUS_STAGES(BUS_STAGES)) u_bus (
    .clk_bus_i(clk_bus_i),
    .rst_ni   (rst_ni),
    .mode_i   (trig_mode_e'(mode_i)),
    .sw_wr_i  (sw_wr_i),
    .ext_i    (ext_i),
    .lvl_o    (bus_lvl)
  );

  trig_op_sync #(.SYNC_STAGES(SYNC_STAGES), .PWM_STAGES(PWM_STAGES)) u_sync (
    .clk_op_i     (clk_op_i),
    .rst_ni       (rst_ni),
    .bus_lvl_i    (bus_lvl),
    .pwm_i        (pwm_i),
    .mode_q_i     (mode_q),
    .mode_stable_i(mode_q == mode_d),
    .rise_o       (rise)
  );

  trig_delay_ctrl #(.DLY_W(DLY_W)) u_dly (
    .clk_op_i(clk_op_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .delay_i (delay_i),
    .start_o (start_o),
    .busy_o  (busy_o)
  );

  AST_MODE_HOLD: assert property (@(posedge clk_op_i) disable iff (!rst_ni)
    busy_o |=> $stable(mode_q)); // R11
endmodule

// File: tb/adc_trig_ctrl_test.sv
module adc_trig_ctrl_test;
  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] src;
    logic [7:0] dly;
    logic [7:0] hold;
    logic [7:0] exp_edge;
    logic [7:0] exp_cnt;
    logic [7:0] extra_k;
    logic [7:0] msw_k;
  } vec_t;

  // mode/src: 0 sw, 1 pwm, 2 ext, 3 off; exp_edge = op edge of start after drive, 0 = none
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 8'd0,  8'd1,  8'd4,  8'd1, 8'd0,  8'd0}, // R2
    '{2'd0, 2'd0, 8'd3,  8'd1,  8'd7,  8'd1, 8'd0,  8'd0}, // R2 R5
    '{2'd2, 2'd2, 8'd0,  8'd3,  8'd4,  8'd1, 8'd0,  8'd0}, // R3
    '{2'd2, 2'd2, 8'd5,  8'd2,  8'd9,  8'd1, 8'd0,  8'd0}, // R3 R5
    '{2'd1, 2'd1, 8'd0,  8'd1,  8'd3,  8'd1, 8'd0,  8'd0}, // R4
    '{2'd1, 2'd1, 8'd1,  8'd1,  8'd4,  8'd1, 8'd0,  8'd0}, // R4 R5
    '{2'd1, 2'd1, 8'd7,  8'd1,  8'd10, 8'd1, 8'd0,  8'd0}, // R5
    '{2'd3, 2'd0, 8'd0,  8'd1,  8'd0,  8'd0, 8'd0,  8'd0}, // R10 off
    '{2'd1, 2'd0, 8'd0,  8'd1,  8'd0,  8'd0, 8'd0,  8'd0}, // R10 sw in pwm mode
    '{2'd0, 2'd1, 8'd0,  8'd1,  8'd0,  8'd0, 8'd0,  8'd0}, // R10 pwm in sw mode
    '{2'd0, 2'd2, 8'd2,  8'd3,  8'd0,  8'd0, 8'd0,  8'd0}, // R10 ext in sw mode
    '{2'd2, 2'd2, 8'd0,  8'd30, 8'd4,  8'd1, 8'd0,  8'd0}, // R9 held level
    '{2'd1, 2'd1, 8'd10, 8'd1,  8'd13, 8'd1, 8'd5,  8'd0}, // R8 pulse while busy
    '{2'd1, 2'd1, 8'd10, 8'd1,  8'd13, 8'd1, 8'd15, 8'd5}  // R11 switch while busy
  };

  logic       clk_bus = 1'b0;
  logic       clk_op  = 1'b0;
  logic       rst_ni  = 1'b0;
  logic [1:0] mode    = 2'd3;
  logic       sw_wr   = 1'b0;
  logic       pwm     = 1'b0;
  logic       ext     = 1'b0;
  logic [7:0] delay   = 8'd0;
  logic       start;
  logic       busy;
  int         n_chk   = 0;
  int         n_bad   = 0;

  always #5 clk_bus = ~clk_bus;
  initial begin
    #3;
    forever #5 clk_op = ~clk_op;
  end

  adc_trig_ctrl uut (
    .clk_bus_i(clk_bus),
    .clk_op_i (clk_op),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .sw_wr_i  (sw_wr),
    .pwm_i    (pwm),
    .ext_i    (ext),
    .delay_i  (delay),
    .start_o  (start),
    .busy_o   (busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input vec_t v);
    int first = 0;
    int starts = 0;
    int busy_n = 0;
    string lat_req;
    lat_req = (v.src == 2'd0) ? "R2 sw latency" :
              (v.src == 2'd1) ? "R4 pwm latency" : "R3 ext latency";
    if (v.exp_edge == 8'd0) lat_req = "R10 unselected source";
    mode  = v.mode;
    delay = v.dly;
    repeat (8) @(posedge clk_op);
    #1;
    case (v.src)
      2'd0:    sw_wr = 1'b1;
      2'd1:    pwm   = 1'b1;
      default: ext   = 1'b1;
    endcase
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk_op);
      #1;
      if (start) begin
        starts++;
        if (first == 0) first = k;
      end
      if (busy) busy_n++;
      if (k == int'(v.hold)) begin
        sw_wr = 1'b0;
        pwm   = 1'b0;
        ext   = 1'b0;
      end
      if (k == int'(v.msw_k)) mode = 2'd0;
      if (k == int'(v.extra_k)) pwm = 1'b1;
      if (v.extra_k != 8'd0 && k == int'(v.extra_k) + 1) pwm = 1'b0;
    end
    chk(lat_req, first, int'(v.exp_edge));
    chk("R6 R8 R9 R11 start count", starts, int'(v.exp_cnt));
    chk("R7 busy cycles", busy_n, (v.exp_cnt != 8'd0) ? int'(v.dly) : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_op);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2;
    chk("R1 start in reset", int'(start), 0);
    chk("R1 busy in reset", int'(busy), 0);
    #40 rst_ni = 1'b1;
    repeat (3) @(posedge clk_op);
    #1;
    chk("R1 start after reset", int'(start), 0);
    chk("R1 busy after reset", int'(busy), 0);

    for (int i = 0; i < NV; i++) run_case(VEC[i]);

    // reset during a delay window
    mode  = 2'd1;
    delay = 8'd20;
    repeat (8) @(posedge clk_op);
    #1 pwm = 1'b1;
    @(posedge clk_op);
    #1 pwm = 1'b0;
    repeat (5) @(posedge clk_op);
    #1;
    chk("R7 busy mid window", int'(busy), 1);
    rst_ni = 1'b0;
    #1;
    chk("R1 busy cleared by reset", int'(busy), 0);
    @(posedge clk_op);
    #1 rst_ni = 1'b1;
    begin
      int late = 0;
      for (int k = 0; k < 40; k++) begin
        @(posedge clk_op);
        #1;
        if (start) late++;
      end
      chk("R1 pending start cancelled", late, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule